// File: doc/BRIEF.md
# Exception Mode Stack Register

This unit holds the privilege and interrupt state of a small RISC core as a three-level stack of bit pairs. Each pair carries an interrupt-enable flag and a user-mode flag. The three pairs sit in the low six bits of a 32-bit status word. When the core takes a trap, the stack is pushed in one cycle: the live pair moves to the middle slot, the middle pair moves to the deepest slot, and a fresh kernel-mode, interrupts-off pair becomes live. When the core returns from a trap, the stack is popped: the middle pair comes back into the live slot, the deepest pair moves up to the middle, and the deepest pair also keeps its own value.

Each trap also captures the address of the faulting instruction and a 5-bit reason code. Software reaches all three registers through a single-cycle port. Reads are combinational and writes take effect at the next clock edge. The live pair is driven straight out to the core as the interrupt-enable and user-mode signals.

Top module: `mode_stack_unit`

## Requirements
- R1: After reset, the status word, the trap address and the reason code all read zero, and both `intEnable` and `userMode` are low. The live pair is therefore kernel mode with interrupts off, and the middle and deepest pairs are cleared.
- R2: `regRdData` is combinational from `regSel`, with this encoding: 0 selects the status word, 1 selects the reason code in bits 4:0 with all other bits zero, 2 selects the trap address, and 3 reads as zero.
- R3: When `regWrEn` is high with `regSel`=0 and no stack operation is active, all 32 bits of `regWrData` are in the status word after the next clock edge.
- R4: When `excTake` is pulsed, the low six status bits become `{old[3:0], 2'b00}`. Bits 1:0 form the live pair (bit 0 is interrupt-enable, bit 1 is user mode), bits 3:2 form the middle pair and bits 5:4 form the deepest pair.
- R5: When `retFromExc` is pulsed alone, the low six bits become `{old[5:4], old[5:2]}`.
- R6: When `excTake` and `retFromExc` are high in the same cycle, only the push of R4 happens.
- R7: On `excTake`, `excPc` is captured as the trap address and `excCause` as the reason code. A return leaves both unchanged, and software writes with `regSel` equal to 1 or 2 have no effect on them.
- R8: A software write to the status word in the same cycle as a push or pop takes only bits 31:6 from `regWrData`. Bits 5:0 follow the stack operation.
- R9: A push or pop never changes status bits 31:6.
- R10: `intEnable` equals status bit 0 and `userMode` equals status bit 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select for reads and writes |
| regWrEn | input | 1 | Software write strobe |
| regWrData | input | 32 | Software write data |
| regRdData | output | 32 | Read data selected by `regSel` |
| excTake | input | 1 | Trap-entry strobe (push) |
| excPc | input | 32 | Address of the faulting instruction |
| excCause | input | 5 | Reason code for the trap |
| retFromExc | input | 1 | Trap-return strobe (pop) |
| intEnable | output | 1 | Live interrupt-enable flag |
| userMode | output | 1 | Live user-mode flag |

## Verification
Three kinds of event can fall in the same cycle: a push together with a pop, and a software status write together with either a push or a pop. The stimulus table drives each of these overlaps from a known status value. The bench checks that a push beats a pop. It also checks that the written word supplies only bits 31:6 while the stack shift supplies bits 5:0. Every expected status value is written into the table by hand from the shift rules.

// File: rtl/mode_stack_pkg.sv
package mode_stack_pkg;
  localparam int DATA_W  = 32;
  localparam int CAUSE_W = 5;
  localparam int PAIR_W  = 2;
  localparam int LEVELS  = 3;
  localparam int STK_W   = PAIR_W * LEVELS;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_TRAPPC = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic pushStack;
    logic popStack;
    logic swWrStatus;
    logic captureTrap;
  } stack_strobes_t;
endpackage

// File: rtl/mode_stack_ctrl.sv
module mode_stack_ctrl
  import mode_stack_pkg::*;
(
  input  logic           excTake,
  input  logic           retFromExc,
  input  logic           regWrEn,
  input  logic [1:0]     regSel,
  output stack_strobes_t strobes
);
  always_comb begin
    strobes.pushStack   = excTake;
    strobes.popStack    = retFromExc & ~excTake;
    strobes.swWrStatus  = regWrEn & (reg_sel_e'(regSel) == SEL_STATUS);
    strobes.captureTrap = excTake;
  end

  // R6: a push and a pop are never issued together
  always_comb begin
    a_r6_push_wins: assert (!(strobes.pushStack && strobes.popStack));
  end
endmodule

// File: rtl/mode_stack_dpath.sv
module mode_stack_dpath
  import mode_stack_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  stack_strobes_t      strobes,
  input  logic [1:0]          regSel,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [DATA_W-1:0]   excPc,
  input  logic [CAUSE_W-1:0]  excCause,
  output logic [DATA_W-1:0]   regRdData,
  output logic                intEnable,
  output logic                userMode
);
  logic [PAIR_W-1:0]       pairQ [LEVELS];
  logic [DATA_W-1:STK_W]   upperQ;
  logic [DATA_W-1:0]       trapPcQ;
  logic [CAUSE_W-1:0]      causeQ;
  logic [STK_W-1:0]        stackFlat;
  logic [DATA_W-1:0]       statusWord;
  logic                    stackOp;

  assign stackOp = strobes.pushStack | strobes.popStack;

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
    logic [PAIR_W-1:0] pushVal;
    logic [PAIR_W-1:0] popVal;
    if (lvl == 0) begin : g_bottom
      assign pushVal = '0;
    end else begin : g_shift_up
      assign pushVal = pairQ[lvl-1];
    end
    if (lvl == LEVELS-1) begin : g_top
      assign popVal = pairQ[lvl];
    end else begin : g_shift_down
      assign popVal = pairQ[lvl+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        pairQ[lvl] <= '0;
      else if (strobes.pushStack)
        pairQ[lvl] <= pushVal;
      else if (strobes.popStack)
        pairQ[lvl] <= popVal;
      else if (strobes.swWrStatus)
        pairQ[lvl] <= regWrData[lvl*PAIR_W +: PAIR_W];
    end

    assign stackFlat[lvl*PAIR_W +: PAIR_W] = pairQ[lvl];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      upperQ <= '0;
    else if (strobes.swWrStatus)
      upperQ <= regWrData[DATA_W-1:STK_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapPcQ <= '0;
      causeQ  <= '0;
    end else if (strobes.captureTrap) begin
      trapPcQ <= excPc;
      causeQ  <= excCause;
    end
  end

  assign statusWord = {upperQ, stackFlat};
  assign intEnable  = pairQ[0][0];
  assign userMode   = pairQ[0][1];

  always_comb begin
    unique case (reg_sel_e'(regSel))
      SEL_STATUS: regRdData = statusWord;
      SEL_CAUSE:  regRdData = {{(DATA_W-CAUSE_W){1'b0}}, causeQ};
      SEL_TRAPPC: regRdData = trapPcQ;
      default:    regRdData = '0;
    endcase
  end

  // R4: a push shifts the stack up and clears the live pair
  a_r4_push_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushStack |=> stackFlat == {$past(stackFlat[STK_W-PAIR_W-1:0]), {PAIR_W{1'b0}}});

  // R5: a pop shifts the stack down and keeps the deepest pair
  a_r5_pop_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobes.popStack |=> stackFlat ==
      {$past(stackFlat[STK_W-1 -: PAIR_W]), $past(stackFlat[STK_W-1:PAIR_W])});

  // R9: a stack operation without a write leaves the upper bits alone
  a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stackOp && !strobes.swWrStatus) |=> $stable(upperQ));

  // R8: a write that coincides with a stack operation still lands in the upper bits
  a_r8_upper_written: assert property (@(posedge clk) disable iff (!rstN)
    (stackOp && strobes.swWrStatus) |=> upperQ == $past(regWrData[DATA_W-1:STK_W]));

  // R7: the trap registers hold still unless a trap is taken
  a_r7_trap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureTrap |=> ($stable(trapPcQ) && $stable(causeQ)));
endmodule

// File: rtl/mode_stack_unit.sv
module mode_stack_unit
  import mode_stack_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          regSel,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic                excTake,
  input  logic [DATA_W-1:0]   excPc,
  input  logic [CAUSE_W-1:0]  excCause,
  input  logic                retFromExc,
  output logic                intEnable,
  output logic                userMode
);
  stack_strobes_t strobes;

  mode_stack_ctrl ctrl_i (
    .excTake    (excTake),
    .retFromExc (retFromExc),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .strobes    (strobes)
  );

  mode_stack_dpath dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regSel    (regSel),
    .regWrData (regWrData),
    .excPc     (excPc),
    .excCause  (excCause),
    .regRdData (regRdData),
    .intEnable (intEnable),
    .userMode  (userMode)
  );
endmodule

// File: tb/mode_stack_unit_tb.sv
module mode_stack_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  regSel;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        excTake;
  logic [31:0] excPc;
  logic [4:0]  excCause;
  logic        retFromExc;
  logic        intEnable;
  logic        userMode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mode_stack_unit dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .excTake(excTake),
    .excPc(excPc), .excCause(excCause), .retFromExc(retFromExc),
    .intEnable(intEnable), .userMode(userMode)
  );

  // vector: {excTake, retFromExc, regWrEn, wdata[31:0], expected status[31:0]}
  localparam int NVEC = 10;
  localparam logic [66:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 32'hABCD_0035, 32'hABCD_0035},  // R3 plain write
    {1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'hABCD_0014},  // R4 push
    {1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'hABCD_0015},  // R5 pop
    {1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'hABCD_0015},  // R5 pop, deepest kept
    {1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'hABCD_0014},  // R6 both, push wins
    {1'b1, 1'b0, 1'b1, 32'h1234_5603, 32'h1234_5610},  // R8 write with push
    {1'b0, 1'b1, 1'b1, 32'hFFFF_FFC2, 32'hFFFF_FFD4},  // R8 write with pop
    {1'b0, 1'b0, 1'b1, 32'h0000_0003, 32'h0000_0003},  // R3 write
    {1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_000C},  // R4 push, R9 upper kept
    {1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0003}   // R5 pop
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(logic ex, logic rt, logic we, logic [1:0] sel,
                       logic [31:0] wd, logic [31:0] pc, logic [4:0] cs);
    @(negedge clk);
    excTake = ex; retFromExc = rt; regWrEn = we; regSel = sel;
    regWrData = wd; excPc = pc; excCause = cs;
    @(negedge clk);
    excTake = 1'b0; retFromExc = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic readReg(logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #0.5;
    val = regRdData;
  endtask

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; regSel = 2'd0; regWrEn = 1'b0; regWrData = '0;
    excTake = 1'b0; excPc = '0; excCause = '0; retFromExc = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(2'd0, rd); check("R1 status", rd, 32'h0);
    readReg(2'd1, rd); check("R1 cause", rd, 32'h0);
    readReg(2'd2, rd); check("R1 trap pc", rd, 32'h0);
    check("R1 outputs", {30'd0, userMode, intEnable}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][66], VEC[i][65], VEC[i][64], 2'd0, VEC[i][63:32],
            32'h0000_1000 + 32'(i * 4), 5'(i));
      readReg(2'd0, rd);
      check($sformatf("vector %0d status (R3/R4/R5/R6/R8/R9)", i), rd, VEC[i][31:0]);
      check($sformatf("vector %0d R10 outputs", i),
            {30'd0, userMode, intEnable}, {30'd0, VEC[i][1:0]});
    end

    // R7 capture on a trap
    cycle(1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 32'hDEAD_BEE0, 5'd19);
    readReg(2'd2, rd); check("R7 trap pc captured", rd, 32'hDEAD_BEE0);
    readReg(2'd1, rd); check("R7/R2 cause captured", rd, 32'h0000_0013);
    // R7 a return does not touch them
    cycle(1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 32'h1111_1111, 5'd7);
    readReg(2'd2, rd); check("R7 trap pc after return", rd, 32'hDEAD_BEE0);
    readReg(2'd1, rd); check("R7 cause after return", rd, 32'h0000_0013);
    // R7 software writes to them are ignored
    cycle(1'b0, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0, 5'd0);
    readReg(2'd1, rd); check("R7 cause write ignored", rd, 32'h0000_0013);
    cycle(1'b0, 1'b0, 1'b1, 2'd2, 32'h0000_0044, 32'h0, 5'd0);
    readReg(2'd2, rd); check("R7 trap pc write ignored", rd, 32'hDEAD_BEE0);
    readReg(2'd0, rd); check("R7 status untouched by those writes", rd, 32'h0000_0003);
    // R2 unused select
    readReg(2'd3, rd); check("R2 select 3 reads zero", rd, 32'h0);

    // R1 reset mid-run clears everything
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readReg(2'd0, rd); check("R1 status after reset", rd, 32'h0);
    readReg(2'd2, rd); check("R1 trap pc after reset", rd, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule